// File: doc/BRIEF.md
# Programmable Supervisor Watchdog Timer

This block watches a host processor for signs that it has stopped running. The host programs one 8-bit control byte over a simple register bus. The byte holds a steering bit, a 5-bit multiplier and a 2-bit resolution code. The time-out is the multiplier times the resolution period. The resolution ticks come from a prescaler that runs all the time from the reference clock, so an expiry is exact only to within one resolution period.

Firmware shows it is alive in one of two ways: it toggles the watchdog input pin in either direction, or it writes the control byte again. Either one restarts the countdown. If the countdown runs out, a sticky flag is set and the steering bit picks the response:

- **Interrupt mode (steering bit 0):** the interrupt output is raised and stays high.
- **Reset mode (steering bit 1):** an active-low reset pulse of fixed length is driven. The control byte is cleared, and a one-cycle strobe tells neighbouring blocks to clear their enable bits.

Reading the flags register clears the flag.

Top module: `wdt_supervisor`

## Requirements
- R1: A write to address 0x09 stores the byte, and a read at 0x09 returns it. Bit 7 is the steering bit, bits 6:2 are the multiplier and bits 1:0 are the resolution code.
- R2: The resolution codes are 0 = 1, 1 = 4, 2 = 16 and 3 = 64 base periods, where one base period (1/16 s) is TICK_DIV reference cycles. Expiry comes no earlier than (M-1) resolution periods and no later than M resolution periods plus 2 cycles after the restart, where M is the multiplier.
- R3: A rising or falling edge on the watchdog pin restarts the countdown from the stored multiplier. Any write to 0x09 also restarts it, from the written multiplier.
- R4: Expiry sets the watchdog flag. In interrupt mode the interrupt output rises and stays high.
- R5: In reset mode, expiry drives the reset output low for exactly RST_LEN reference cycles and leaves the interrupt output low.
- R6: A reset-mode expiry clears the control byte to 0x00 and pulses the neighbour-clear output for exactly one cycle.
- R7: A pending interrupt is cleared only by a watchdog-pin edge or by a write of 0x00. A non-zero write leaves it high. After a 0x00 write the timer stays idle.
- R8: A read at address 0x0F returns the watchdog flag in bit 7, and that read clears the flag. If an expiry happens in the same cycle, the set wins.
- R9: After reset the control byte is 0x00, the flag and interrupt are low, the reset output is high and the timer is idle.
- R10: A multiplier of zero disables the timer whatever the resolution bits hold, and no expiry occurs.
- R11: When a restart and an expiry fall in the same cycle, the restart wins and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Synchronous active-low power-up reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| wdi_i | input | 1 | Watchdog kick pin (asynchronous) |
| wdt_flag_o | output | 1 | Sticky watchdog flag |
| wdt_irq_o | output | 1 | Interrupt output, active high |
| cpu_rst_no | output | 1 | Reset pulse output, active low |
| cfg_clr_o | output | 1 | One-cycle strobe that clears neighbour enable bits |

## Verification
The bench programs all four resolutions and both steering modes. It times each expiry against the window the requirements allow. A prescaler tapped at the wrong stage, or a countdown that is off by a whole period, lands outside that window.

It keeps the timer alive with pin edges and with repeated writes. A design that sees only one edge polarity, or that ignores writes as restarts, would fire during those phases.

It checks that a non-zero write leaves a pending interrupt high. It also checks that a zero multiplier with the slowest resolution code never expires. A design that confuses the clear rule, or that reads a zero multiplier as 32, fails these checks.

In reset mode it counts the low cycles of the reset output and the neighbour-clear strobes. An off-by-one pulse counter, or a strobe that lasts more than one cycle, shows up as a wrong count.

// File: rtl/wdt_pkg.sv
// Shared types for the supervisor watchdog.
// Assumes a control byte laid out as {steer, multiplier[4:0], resolution[1:0]}.
package wdt_pkg;
    localparam int NUM_RES = 4;
    localparam int MULT_W  = 5;

    typedef enum logic [1:0] {
        RES_SIXTEENTH = 2'd0,
        RES_QUARTER   = 2'd1,
        RES_ONE       = 2'd2,
        RES_FOUR      = 2'd3
    } wdt_res_e;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        wdt_res_e          res;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_tick_gen.sv
// Free-running resolution tick generator.
// One base tick every TICK_DIV reference cycles. Each coarser tick is four times
// slower than the one before it. Assumes TICK_DIV >= 2. Restarts never reset it.
module wdt_tick_gen #(
    parameter int TICK_DIV = 2048,
    parameter int NUM_RES  = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    output logic [NUM_RES-1:0] tick_o
);
    localparam int DIV_W = $clog2(TICK_DIV);
    localparam int SUB_W = 2 * (NUM_RES - 1);

    logic [DIV_W-1:0] div_q;
    logic [SUB_W-1:0] sub_q;
    logic             base_tick;

    assign base_tick = (div_q == DIV_W'(TICK_DIV - 1));

    // Prescaler: reference cycles to base ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        div_q <= '0;
        else if (base_tick) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Sub-counter of base ticks, feeding the coarser resolutions.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        sub_q <= '0;
        else if (base_tick) sub_q <= sub_q + 1'b1;
    end

    for (genvar k = 0; k < NUM_RES; k++) begin : g_tick
        if (k == 0) begin : g_base
            assign tick_o[k] = base_tick;
        end else begin : g_coarse
            assign tick_o[k] = base_tick & (&sub_q[2*k-1:0]);
        end
    end
endmodule

// File: rtl/wdt_sync_edge.sv
// Two-flop synchronizer followed by a detector for edges of either polarity.
// Assumes the pin is slow compared with the clock. The edge pulse lasts one cycle.
module wdt_sync_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic edge_o
);
    logic [1:0] sync_q;
    logic       prev_q;

    // Synchronize the pin, then keep the previous synchronized value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            prev_q <= sync_q[1];
        end
    end

    assign edge_o = sync_q[1] ^ prev_q;
endmodule

// File: rtl/wdt_core.sv
// Countdown, flag, interrupt and reset-pulse logic.
// Assumes one-cycle strobes for the write, pin edge and flag read.
// On a same-cycle conflict, a restart wins over an expiry.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int RST_LEN = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_RES-1:0] tick_i,
    input  logic               cfg_wr_i,
    input  wdt_cfg_t           cfg_wdata_i,
    input  logic               pin_edge_i,
    input  logic               flag_rd_i,
    output wdt_cfg_t           cfg_o,
    output logic               flag_o,
    output logic               irq_o,
    output logic               rst_no,
    output logic               clr_o,
    output logic               expire_o,
    output logic               restart_o
);
    localparam int RST_W = $clog2(RST_LEN + 1);

    wdt_cfg_t          cfg_q;
    logic [MULT_W-1:0] cnt_q;
    logic [MULT_W-1:0] load_mult;
    logic              armed_q;
    logic              tick_sel;
    logic [RST_W-1:0]  rst_cnt_q;
    logic              zero_wr;

    assign restart_o = cfg_wr_i | pin_edge_i;
    assign load_mult = cfg_wr_i ? cfg_wdata_i.mult : cfg_q.mult;
    assign tick_sel  = tick_i[cfg_q.res];
    assign expire_o  = armed_q & tick_sel & (cnt_q == MULT_W'(1)) & ~restart_o;
    assign zero_wr   = cfg_wr_i & (cfg_wdata_i == '0);

    // Control byte: loaded by the host, cleared on a reset-mode expiry.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        cfg_q <= '0;
        else if (cfg_wr_i)                  cfg_q <= cfg_wdata_i;
        else if (expire_o && cfg_q.steer)   cfg_q <= '0;
    end

    // Countdown: reloaded on restart, one step per selected tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (restart_o) begin
            cnt_q   <= load_mult;
            armed_q <= (load_mult != '0);
        end else if (expire_o) begin
            armed_q <= 1'b0;
        end else if (armed_q && tick_sel) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Sticky flag: set by expiry, cleared by a flags read.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        flag_o <= 1'b0;
        else if (expire_o)  flag_o <= 1'b1;
        else if (flag_rd_i) flag_o <= 1'b0;
    end

    // Interrupt: set by an interrupt-mode expiry, cleared by a pin edge or a zero write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       irq_o <= 1'b0;
        else if (expire_o && !cfg_q.steer) irq_o <= 1'b1;
        else if (pin_edge_i || zero_wr)    irq_o <= 1'b0;
    end

    // Reset pulse length counter and the neighbour-clear strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rst_cnt_q <= '0;
            clr_o     <= 1'b0;
        end else begin
            clr_o <= expire_o & cfg_q.steer;
            if (expire_o && cfg_q.steer) rst_cnt_q <= RST_W'(RST_LEN);
            else if (rst_cnt_q != '0)    rst_cnt_q <= rst_cnt_q - 1'b1;
        end
    end

    assign rst_no = (rst_cnt_q == '0);
    assign cfg_o  = cfg_q;
endmodule

// File: rtl/wdt_supervisor.sv
// Top level: register decode, pin synchronizer, tick generator and watchdog core.
// Assumes a single reference clock and a read path without wait states.
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] WD_ADDR   = 8'h09,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0F,
    parameter int              TICK_DIV  = 2048,
    parameter int              RST_LEN   = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              wdi_i,
    output logic              wdt_flag_o,
    output logic              wdt_irq_o,
    output logic              cpu_rst_no,
    output logic              cfg_clr_o
);
    logic [NUM_RES-1:0] tick;
    logic               pin_edge;
    logic               cfg_wr;
    logic               flag_rd;
    logic               expire;
    logic               restart;
    wdt_cfg_t           cfg;

    assign cfg_wr  = reg_wr_i & (reg_addr_i == WD_ADDR);
    assign flag_rd = reg_rd_i & (reg_addr_i == FLAG_ADDR);

    wdt_tick_gen #(.TICK_DIV(TICK_DIV), .NUM_RES(NUM_RES)) u_tick (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    wdt_sync_edge u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (wdi_i),
        .edge_o(pin_edge)
    );

    wdt_core #(.RST_LEN(RST_LEN)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .cfg_wr_i   (cfg_wr),
        .cfg_wdata_i(wdt_cfg_t'(reg_wdata_i)),
        .pin_edge_i (pin_edge),
        .flag_rd_i  (flag_rd),
        .cfg_o      (cfg),
        .flag_o     (wdt_flag_o),
        .irq_o      (wdt_irq_o),
        .rst_no     (cpu_rst_no),
        .clr_o      (cfg_clr_o),
        .expire_o   (expire),
        .restart_o  (restart)
    );

    // Read mux for the control byte and the flags register.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == WD_ADDR)        reg_rdata_o = cfg;
        else if (reg_addr_i == FLAG_ADDR) reg_rdata_o = {wdt_flag_o, 7'b0};
    end
endmodule

// File: rtl/wdt_supervisor_chk.sv
// Property checker bound to the watchdog top.
// It watches the ports plus the internal expiry, restart and pin-edge strobes.
module wdt_supervisor_chk #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] WD_ADDR   = 8'h09,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0F,
    parameter int              RST_LEN   = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [7:0]        reg_wdata_i,
    input logic              wdt_flag_o,
    input logic              wdt_irq_o,
    input logic              cpu_rst_no,
    input logic              cfg_clr_o,
    input logic              expire,
    input logic              restart,
    input logic              pin_edge,
    input logic [7:0]        cfg_byte
);
    localparam int LW = $clog2(RST_LEN + 2) + 1;
    logic [LW-1:0] low_cnt;
    logic          zero_wr;
    logic          flag_rd;

    assign zero_wr = reg_wr_i && reg_addr_i == WD_ADDR && reg_wdata_i == 8'h00;
    assign flag_rd = reg_rd_i && reg_addr_i == FLAG_ADDR;

    // Count consecutive low cycles of the reset output.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         low_cnt <= '0;
        else if (cpu_rst_no) low_cnt <= '0;
        else                 low_cnt <= low_cnt + 1'b1;
    end

    // R4
    irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_irq_o && !pin_edge && !zero_wr |=> wdt_irq_o);
    // R4
    flag_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> wdt_flag_o);
    // R5
    rst_low_after_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire && cfg_byte[7] |=> !cpu_rst_no && !$rose(wdt_irq_o));
    // R5
    rst_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cpu_rst_no) |-> low_cnt == LW'(RST_LEN));
    // R6
    clr_clears_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_clr_o |-> cfg_byte == 8'h00);
    // R6
    clr_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_clr_o |=> !cfg_clr_o);
    // R8
    flag_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_rd && !expire |=> !wdt_flag_o);
    // R10
    zero_mult_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_byte[6:2] == 5'd0 |-> !expire);
    // R11
    restart_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart && !wdt_flag_o |=> !wdt_flag_o);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(
    .ADDR_W(ADDR_W), .WD_ADDR(WD_ADDR), .FLAG_ADDR(FLAG_ADDR), .RST_LEN(RST_LEN)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .wdt_flag_o (wdt_flag_o),
    .wdt_irq_o  (wdt_irq_o),
    .cpu_rst_no (cpu_rst_no),
    .cfg_clr_o  (cfg_clr_o),
    .expire     (expire),
    .restart    (restart),
    .pin_edge   (pin_edge),
    .cfg_byte   (cfg)
);

// File: tb/wdt_supervisor_bench.sv
// Self-checking bench for the supervisor watchdog.
// A vector table covers the mode and resolution mix; directed tests follow.
module wdt_supervisor_bench;
    localparam int TDIV = 4;
    localparam int RLEN = 12;
    localparam logic [7:0] WA = 8'h09;
    localparam logic [7:0] FA = 8'h0F;
    localparam int NV = 6;
    localparam logic [7:0] VEC [NV] = '{8'h05, 8'h0C, 8'h0E, 8'h7C, 8'h87, 8'h89};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, wdi = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       flag, irq, crst_n, clr;
    int         checks = 0, fails = 0, clr_seen = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    wdt_supervisor #(.TICK_DIV(TDIV), .RST_LEN(RLEN)) u_wdt_supervisor (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .wdi_i(wdi), .wdt_flag_o(flag), .wdt_irq_o(irq),
        .cpu_rst_no(crst_n), .cfg_clr_o(clr)
    );

    always @(negedge clk) if (clr) clr_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic toggle_pin();
        @(negedge clk); wdi = ~wdi;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n, lo, hi, per, m, lowc, gotirq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        reg_read(WA, d);  check("R9 cfg after reset", d, 0);
        check("R9 irq after reset", irq, 0);
        check("R9 rst_n after reset", crst_n, 1);
        reg_read(FA, d);  check("R9 flag after reset", d, 0);

        // Vector loop: R1, R2, R4, R5, R6, R7, R8
        foreach (VEC[i]) begin
            m   = VEC[i][6:2];
            per = TDIV << (2 * VEC[i][1:0]);
            clr_seen = 0;
            reg_write(WA, VEC[i]);
            reg_read(WA, d);  check("R1 readback", d, VEC[i]);
            n = 2;
            while (!irq && crst_n && n < m * per + 20) begin @(negedge clk); n++; end
            lo = (m - 1) * per; hi = m * per + 2;
            check_range("R2 expiry time", n, lo, hi);
            if (!VEC[i][7]) begin
                check("R4 irq raised", irq, 1);
                check("R4 rst_n stays high", crst_n, 1);
                reg_read(FA, d);  check("R4 flag set", d[7], 1);
                reg_read(FA, d);  check("R8 flag cleared by read", d[7], 0);
                reg_write(WA, VEC[i]);
                check("R7 nonzero write keeps irq", irq, 1);
                reg_write(WA, 8'h00);
                check("R7 zero write clears irq", irq, 0);
            end else begin
                lowc = 0; gotirq = 0;
                while (!crst_n && lowc < RLEN + 20) begin
                    lowc++; if (irq) gotirq = 1; @(negedge clk);
                end
                check("R5 reset pulse length", lowc, RLEN);
                check("R5 irq stays low", gotirq, 0);
                check("R6 one clear strobe", clr_seen, 1);
                reg_read(WA, d);  check("R6 cfg cleared", d, 0);
                reg_read(FA, d);  check("R4 flag set reset mode", d[7], 1);
                reg_read(FA, d);  check("R8 flag cleared reset mode", d[7], 0);
            end
            idle(300);
            check("R7 idle after clear", irq | !crst_n, 0);
        end

        // R10 zero multiplier with the slowest resolution
        reg_write(WA, 8'h03);
        idle(700);
        check("R10 zero mult no irq", irq, 0);
        reg_read(FA, d);  check("R10 zero mult no flag", d[7], 0);

        // R3 pin edges of both polarities keep the timer alive (m=2, P=16)
        reg_write(WA, 8'h09);
        for (int k = 0; k < 30; k++) begin toggle_pin(); idle(4); end
        check("R3 pin keepalive no irq", irq, 0);
        // R3 repeated writes keep it alive
        for (int k = 0; k < 20; k++) begin reg_write(WA, 8'h09); idle(8); end
        check("R3 write keepalive no irq", irq, 0);
        reg_read(FA, d);  check("R3 keepalive no flag", d[7], 0);
        idle(40);
        check("R4 irq after keepalive stops", irq, 1);
        toggle_pin();
        check("R7 pin edge clears irq", irq, 0);
        reg_write(WA, 8'h00);
        reg_read(FA, d);  check("R8 flag was set", d[7], 1);
        reg_read(FA, d);  check("R8 flag now clear", d[7], 0);
        idle(100);
        check("R7 stays idle after zero write", irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule